// File: doc/BRIEF.md
# Synthesizer Configuration Word Loader

This block is the programming front end of a frequency synthesizer. It produces three configuration fields: a feedback divide value, an output divide code and a test select code. The fields can be loaded in two ways. The first is a three-wire serial port made of a serial clock, a serial data line and a load strobe. The second is a parallel bus that carries the two divide fields and is gated by an active-low parallel load pin. The phase-locked loop, its oscillator and the analog drivers are outside this block. Only the shift register, the configuration register and the test output selector are inside it.

The serial port fills a shift register of `M_W + N_W + T_W` bits. A rising edge on the load strobe copies the whole word into the configuration register. While the parallel load pin is low, the register follows the parallel bus. During that time the test select is forced to zero. Test select zero routes the most significant bit of the shift register to the test output, so the contents of the shift register can be read back bit by bit on one pin. All inputs are sampled on the system clock `clk`, and the serial clock is edge-detected in that domain.

Top module: `synth_cfg_loader`

## Requirements
- R1: A synchronous active-high `rst` clears the shift register, `cfg_m`, `cfg_n`, `cfg_t`, `sr_out` and `test_out` to zero.
- R2: The shift register moves by exactly one bit for each rising edge of `ser_clk`, whatever the length of the high phase. The new bit from `ser_data` enters at bit 0.
- R3: Word layout: bits [M_W-1:0] hold the feedback divide value, the next N_W bits hold the output divide code, and the top T_W bits hold the test select. The first bit shifted in ends at the top bit, so the serial order is T high bit first, then N, then M from its high bit down to bit 0.
- R4: A rising edge of `ser_load` copies all word bits into `cfg_t`, `cfg_n` and `cfg_m`. The new values are visible after that clock edge. Holding `ser_load` high does not load again.
- R5: When there is no load event, the configuration outputs do not change. This holds while new bits are being shifted in.
- R6: While `par_load_n` is low, `cfg_m` and `cfg_n` take `par_m` and `par_n` on every clock and `cfg_t` is held at 0. When `par_load_n` goes high, the last values are frozen.
- R7: If `par_load_n` is low in the same cycle as a `ser_load` rising edge, the parallel load wins.
- R8: With `cfg_t` = 0, `test_out` equals `sr_out`, the top bit of the shift register, one clock later. Shifting therefore presents the stored word on `test_out`, first-shifted bit first.
- R9: The test select codes are: 1 drives `test_out` high, 5 drives it low, and every other nonzero code k drives `tap_in[k]`. In all cases `test_out` is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Serial shift clock, sampled on clk |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Serial load strobe, acts on its rising edge |
| par_load_n | input | 1 | Parallel load, active low and transparent |
| par_m | input | M_W | Parallel feedback divide value |
| par_n | input | N_W | Parallel output divide code |
| tap_in | input | 2**T_W | Signals that the test selector can route to its output |
| cfg_m | output | M_W | Configured feedback divide value |
| cfg_n | output | N_W | Configured output divide code |
| cfg_t | output | T_W | Configured test select |
| sr_out | output | 1 | Top bit of the shift register |
| test_out | output | 1 | Registered test output |

## Verification
The bench builds the block with its default widths: a 9-bit feedback field, a 2-bit divide code and a 3-bit test select. These give a 14-bit word and an 8-input test selector. With those values every test select code can be reached, including the two fixed levels, so each one is checked against two complementary tap patterns. A full 14-bit read-back can be run, and it lines up the serial bit order against the field positions. The 9-bit field is wide enough to tell values that differ only in the bits next to the divide code apart.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  // Test select codes with a fixed meaning
  localparam int SEL_READBACK = 0;
  localparam int SEL_HIGH     = 1;
  localparam int SEL_LOW      = 5;
endpackage

// File: rtl/scl_rise_det.sv
module scl_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level;
  end

  assign rise = level & ~level_q;
endmodule

// File: rtl/scl_shift.sv
module scl_shift #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word,
  output logic         msb
);
  always_ff @(posedge clk) begin
    if (rst)           word <= '0;
    else if (shift_en) word <= {word[W-2:0], din};
  end

  assign msb = word[W-1];

  // R2: one step per detected edge, new bit at position 0
  a_r2_shift: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (word == {$past(word[W-2:0]), $past(din)}));
  // R2: no movement without an edge
  a_r2_idle: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(word));
endmodule

// File: rtl/scl_cfg_latch.sv
module scl_cfg_latch #(
  parameter int M_W = 9,
  parameter int N_W = 2,
  parameter int T_W = 3,
  localparam int W  = M_W + N_W + T_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           par_open,
  input  logic           ser_take,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic [W-1:0]   sr_word,
  output logic [M_W-1:0] cfg_m,
  output logic [N_W-1:0] cfg_n,
  output logic [T_W-1:0] cfg_t
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_m <= '0;
      cfg_n <= '0;
      cfg_t <= '0;
    end else if (par_open) begin
      cfg_m <= par_m;
      cfg_n <= par_n;
      cfg_t <= '0;
    end else if (ser_take) begin
      {cfg_t, cfg_n, cfg_m} <= sr_word;
    end
  end

  // R1: reset clears the configuration
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (cfg_m == '0 && cfg_n == '0 && cfg_t == '0));
  // R4: serial load copies the whole word
  a_r4_serial: assert property (@(posedge clk) disable iff (rst)
    (ser_take && !par_open) |=> ({cfg_t, cfg_n, cfg_m} == $past(sr_word)));
  // R5: no load event, no change
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!ser_take && !par_open) |=> ($stable(cfg_m) && $stable(cfg_n) && $stable(cfg_t)));
  // R6 / R7: open parallel path tracks the bus and clears the test field
  a_r6_follow: assert property (@(posedge clk) disable iff (rst)
    par_open |=> (cfg_m == $past(par_m) && cfg_n == $past(par_n) && cfg_t == '0));
endmodule

// File: rtl/scl_test_mux.sv
module scl_test_mux #(
  parameter int T_W = 3,
  localparam int TAPS = 2 ** T_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [T_W-1:0]  sel,
  input  logic            readback,
  input  logic [TAPS-1:0] tap_in,
  output logic            test_out
);
  import synth_cfg_pkg::*;

  logic pick;

  always_comb begin
    if (sel == T_W'(SEL_READBACK))  pick = readback;
    else if (sel == T_W'(SEL_HIGH)) pick = 1'b1;
    else if (sel == T_W'(SEL_LOW))  pick = 1'b0;
    else                            pick = tap_in[sel];
  end

  always_ff @(posedge clk) begin
    if (rst) test_out <= 1'b0;
    else     test_out <= pick;
  end

  // R8: read-back path, one register of delay
  a_r8_readback: assert property (@(posedge clk) disable iff (rst)
    (sel == T_W'(SEL_READBACK)) |=> (test_out == $past(readback)));
  // R9: fixed-high code
  a_r9_high: assert property (@(posedge clk) disable iff (rst)
    (sel == T_W'(SEL_HIGH)) |=> test_out);
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader #(
  parameter int M_W = 9,
  parameter int N_W = 2,
  parameter int T_W = 3,
  localparam int W    = M_W + N_W + T_W,
  localparam int TAPS = 2 ** T_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ser_clk,
  input  logic            ser_data,
  input  logic            ser_load,
  input  logic            par_load_n,
  input  logic [M_W-1:0]  par_m,
  input  logic [N_W-1:0]  par_n,
  input  logic [TAPS-1:0] tap_in,
  output logic [M_W-1:0]  cfg_m,
  output logic [N_W-1:0]  cfg_n,
  output logic [T_W-1:0]  cfg_t,
  output logic            sr_out,
  output logic            test_out
);
  logic         shift_en;
  logic         take_en;
  logic [W-1:0] sr_word;

  scl_rise_det u_sclk (.clk(clk), .rst(rst), .level(ser_clk),  .rise(shift_en));
  scl_rise_det u_sld  (.clk(clk), .rst(rst), .level(ser_load), .rise(take_en));

  scl_shift #(.W(W)) u_shift (
    .clk(clk), .rst(rst), .shift_en(shift_en), .din(ser_data),
    .word(sr_word), .msb(sr_out)
  );

  scl_cfg_latch #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_latch (
    .clk(clk), .rst(rst), .par_open(~par_load_n), .ser_take(take_en),
    .par_m(par_m), .par_n(par_n), .sr_word(sr_word),
    .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_t(cfg_t)
  );

  scl_test_mux #(.T_W(T_W)) u_tmux (
    .clk(clk), .rst(rst), .sel(cfg_t), .readback(sr_out),
    .tap_in(tap_in), .test_out(test_out)
  );
endmodule

// File: tb/sim_synth_cfg_loader.sv
module sim_synth_cfg_loader;
  localparam int CLK_PERIOD = 10;
  localparam int M_W = 9;
  localparam int N_W = 2;
  localparam int T_W = 3;
  localparam int W = M_W + N_W + T_W;
  localparam int TAPS = 2 ** T_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0, par_load_n = 1'b1;
  logic [M_W-1:0] par_m = '0;
  logic [N_W-1:0] par_n = '0;
  logic [TAPS-1:0] tap_in = '0;
  logic [M_W-1:0] cfg_m;
  logic [N_W-1:0] cfg_n;
  logic [T_W-1:0] cfg_t;
  logic sr_out, test_out;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_cfg_loader #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u0 (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .par_load_n(par_load_n), .par_m(par_m), .par_n(par_n),
    .tap_in(tap_in), .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_t(cfg_t),
    .sr_out(sr_out), .test_out(test_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic shift_bit(input logic b, input int high_cycles);
    ser_data = b;
    ser_clk = 1'b1;
    repeat (high_cycles) tick();
    ser_clk = 1'b0;
    tick();
  endtask

  task automatic shift_word(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) shift_bit(w[i], 1);
  endtask

  task automatic ser_pulse();
    ser_load = 1'b1;
    tick();
    ser_load = 1'b0;
    tick();
  endtask

  task automatic par_pulse(input logic [M_W-1:0] m, input logic [N_W-1:0] n);
    par_m = m;
    par_n = n;
    par_load_n = 1'b0;
    tick();
    par_load_n = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    chk("R1 cfg_m", 32'(cfg_m), 0);
    chk("R1 cfg_n", 32'(cfg_n), 0);
    chk("R1 cfg_t", 32'(cfg_t), 0);
    chk("R1 sr_out", 32'(sr_out), 0);
    chk("R1 test_out", 32'(test_out), 0);
  endtask

  task automatic t_serial_load();
    logic [W-1:0] words [4];
    words[0] = 14'b101_10_100000001;
    words[1] = 14'b010_01_011111110;
    words[2] = W'($urandom);
    words[3] = W'($urandom);
    foreach (words[k]) begin
      shift_word(words[k]);
      ser_pulse();
      chk("R3 R4 cfg_m", 32'(cfg_m), 32'(words[k][M_W-1:0]));
      chk("R3 R4 cfg_n", 32'(cfg_n), 32'(words[k][M_W+N_W-1:M_W]));
      chk("R3 R4 cfg_t", 32'(cfg_t), 32'(words[k][W-1:M_W+N_W]));
    end
  endtask

  task automatic t_hold();
    logic [W-1:0] a, b;
    a = 14'b011_11_001010101;
    b = 14'b100_00_110101010;
    shift_word(a);
    ser_load = 1'b1;
    tick();
    shift_word(b);   // strobe still high: no second load
    chk("R4 held strobe m", 32'(cfg_m), 32'(a[M_W-1:0]));
    chk("R4 held strobe t", 32'(cfg_t), 32'(a[W-1:M_W+N_W]));
    ser_load = 1'b0;
    tick();
    shift_word(a);   // shifting without load
    chk("R5 hold m", 32'(cfg_m), 32'(a[M_W-1:0]));
    chk("R5 hold n", 32'(cfg_n), 32'(a[M_W+N_W-1:M_W]));
    ser_pulse();
    chk("R4 reload m", 32'(cfg_m), 32'(a[M_W-1:0]));
  endtask

  task automatic t_parallel();
    par_m = 9'h1A5;
    par_n = 2'd2;
    par_load_n = 1'b0;
    tick();
    chk("R6 follow m", 32'(cfg_m), 32'h1A5);
    chk("R6 follow n", 32'(cfg_n), 2);
    chk("R6 t cleared", 32'(cfg_t), 0);
    par_m = 9'h05A;
    par_n = 2'd1;
    tick();
    chk("R6 transparent m", 32'(cfg_m), 32'h05A);
    par_load_n = 1'b1;
    tick();
    par_m = 9'h0F0;
    par_n = 2'd3;
    tick();
    tick();
    chk("R6 frozen m", 32'(cfg_m), 32'h05A);
    chk("R6 frozen n", 32'(cfg_n), 1);
  endtask

  task automatic t_priority();
    shift_word(14'b111_11_111111111);
    par_m = 9'h033;
    par_n = 2'd0;
    par_load_n = 1'b0;
    ser_load = 1'b1;
    tick();
    par_load_n = 1'b1;
    ser_load = 1'b0;
    tick();
    chk("R7 priority m", 32'(cfg_m), 32'h033);
    chk("R7 priority n", 32'(cfg_n), 0);
    chk("R7 priority t", 32'(cfg_t), 0);
  endtask

  task automatic t_readback();
    logic [W-1:0] w;
    w = 14'b110_01_101100111;
    shift_word(w);
    par_pulse(9'h000, 2'd0);
    chk("R8 t zero", 32'(cfg_t), 0);
    chk("R8 first bit", 32'(test_out), 32'(w[W-1]));
    chk("R8 sr_out", 32'(sr_out), 32'(w[W-1]));
    for (int i = W - 2; i >= 0; i--) begin
      // one long high phase checks that a held clock shifts once (R2)
      shift_bit(1'b0, (i == 7) ? 4 : 1);
      chk("R2 R3 R8 readback bit", 32'(test_out), 32'(w[i]));
    end
  endtask

  task automatic t_testsel();
    logic [TAPS-1:0] pats [2];
    pats[0] = 8'b1010_1100;
    pats[1] = 8'b0101_0011;
    foreach (pats[p]) begin
      tap_in = pats[p];
      for (int c = 1; c < TAPS; c++) begin
        logic exp;
        shift_word({T_W'(c), 2'd0, 9'h000});
        ser_pulse();
        tick();
        if (c == 1)      exp = 1'b1;
        else if (c == 5) exp = 1'b0;
        else             exp = pats[p][c];
        chk("R9 test select", 32'(test_out), 32'(exp));
      end
    end
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_serial_load();
    t_hold();
    t_parallel();
    t_priority();
    t_readback();
    t_testsel();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule